// File: doc/BRIEF.md
# Sticky Hardware-Monitor Event Status Register

This block holds an 8-bit, read-only status register for a hardware monitor. Each bit latches one event condition. The events are:

- the 12V supply reading leaving its programmed window;
- any of four fan tachometer readings rising above its programmed 16-bit minimum;
- an open or short fault on either of two remote temperature diodes.

A bit is set on the clock edge where its condition is seen. It then stays set until software reads the register. A read clears only those bits whose conditions have gone away. A bit whose condition is still present survives the read.

Next to the register, the block forces a faulted diode's temperature reading to the value 80h while monitoring runs. It keeps a sticky zone limit-exceeded flag per diode. That flag is set by the forced reading or by the raw reading going over a zone limit. The block also drives a summary flag. The summary flag is high whenever any bit is set here or the companion status register reports a set bit. Clearing a diode's enable wipes that diode's fault bit and its zone flag. The bus protocol and the analog conversion are outside the block. The bus protocol is seen only as read and write strobes.

Top module: `hwmon_evt_status`

## Requirements
- R1: After reset `stat_value` is 00h and `zone_flag` is 0. The bit layout is: bit 0 is the 12V error, bit 1 is reserved and always reads 0, bits 2 to 5 are fans 1 to 4, and bits 6 and 7 are the faults of diodes 1 and 2.
- R2: Bit 0 is set on the next clock edge when `v12_rd` is less than or equal to `v12_lo`, or strictly greater than `v12_hi` (unsigned). A reading equal to the high limit does not set it.
- R3: Fan bit k+2 (k = 0 to 3) is set on the next edge when tach reading k, taken from bits [16k+15:16k] of `tach_rd`, is strictly greater than minimum k in the same bits of `tach_min`. Equality does not set it.
- R4: Diode bit d+6 is set on the next edge when `diode_fault[d]` and `diode_en[d]` are both high.
- R5: A set bit stays set when no read occurs, even after its condition goes away.
- R6: A cycle with `rd_stb` high returns the pre-clear contents on `stat_value`. At that edge, every bit whose condition is inactive clears, and every bit whose condition is active stays set. A diode fault bit therefore cannot be read-cleared while its fault persists.
- R7: A condition that is asserted in the same cycle as a read sets its bit; setting wins over clearing.
- R8: When `diode_en[d]` is low at a clock edge, the diode's fault bit and `zone_flag[d]` are 0 after that edge, whatever the fault input.
- R9: Diode d's slice of `temp_out` is 80h while `monitor_start`, `diode_en[d]` and `diode_fault[d]` are all high. Otherwise the slice equals the matching slice of `temp_raw`. This output is combinational.
- R10: `zone_flag[d]` is set on the next edge when the diode is enabled and either its reading is forced (R9) or its raw reading is strictly above its `zone_lim` slice (unsigned). The flag is sticky. `zone_rd_stb` clears it only when its condition is inactive.
- R11: `wr_stb` and `wr_data` never change any register bit.
- R12: `any_event` equals the OR of all `stat_value` bits and `peer_any`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| v12_rd | input | VOLT_W | 12V supply reading |
| v12_lo | input | VOLT_W | 12V low limit (at or below is an error) |
| v12_hi | input | VOLT_W | 12V high limit (above is an error) |
| tach_rd | input | 4*TACH_W | Four packed tach readings, fan 1 in the low slice |
| tach_min | input | 4*TACH_W | Four packed tach minimums |
| diode_en | input | 2 | Remote diode enables |
| diode_fault | input | 2 | Remote diode open/short fault detected |
| monitor_start | input | 1 | Monitoring running; allows the forced reading |
| temp_raw | input | 2*TEMP_W | Raw diode temperature readings |
| zone_lim | input | 2*TEMP_W | Zone limits for the diode readings |
| zone_rd_stb | input | 1 | Read of the register that holds the zone flags |
| peer_any | input | 1 | Companion status register has a set bit |
| rd_stb | input | 1 | Read of this status register |
| wr_stb | input | 1 | Write attempt to this status register |
| wr_data | input | 8 | Write data (ignored) |
| stat_value | output | 8 | Register contents |
| any_event | output | 1 | Summary flag |
| temp_out | output | 2*TEMP_W | Diode readings after fault forcing |
| zone_flag | output | 2 | Sticky zone limit-exceeded flags |

## Verification
The assertions watch the following on every cycle:

- the reserved bit;
- that a condition always sets its bit on the next edge;
- that no bit drops without a read or a disable;
- that a read leaves no bit set whose condition was inactive;
- the disable clear, the forced 80h reading, the zone flag set and the summary flag;
- that a write lets no bit rise without a condition.

Only the bench's scenarios can show the following:

- the exact window boundaries (a reading equal to the low limit sets the bit, one equal to the high limit does not);
- that the value returned on a read is the pre-clear contents;
- the set-over-clear priority in a single cycle;
- that a diode fault bit survives repeated reads.

A behavioural reference model checks all of these against randomized traffic.

// File: rtl/hwmon_stat_pkg.sv
package hwmon_stat_pkg;
  localparam int STAT_W     = 8;
  localparam int N_FAN      = 4;
  localparam int N_DIODE    = 2;
  localparam int BIT_V12    = 0;
  localparam int BIT_RSV    = 1;
  localparam int BIT_FAN0   = 2;
  localparam int BIT_DIODE0 = BIT_FAN0 + N_FAN;
endpackage

// File: rtl/hwmon_evt_detect.sv
module hwmon_evt_detect
  import hwmon_stat_pkg::*;
#(
  parameter int VOLT_W = 8,
  parameter int TACH_W = 16
) (
  input  logic [VOLT_W-1:0]       v12_rd,
  input  logic [VOLT_W-1:0]       v12_lo,
  input  logic [VOLT_W-1:0]       v12_hi,
  input  logic [N_FAN*TACH_W-1:0] tach_rd,
  input  logic [N_FAN*TACH_W-1:0] tach_min,
  input  logic [N_DIODE-1:0]      diode_en,
  input  logic [N_DIODE-1:0]      diode_fault,
  output logic [STAT_W-1:0]       evt_cond
);
  function automatic logic window_viol(input logic [VOLT_W-1:0] r,
                                       input logic [VOLT_W-1:0] lo,
                                       input logic [VOLT_W-1:0] hi);
    return (r <= lo) || (r > hi);
  endfunction

  function automatic logic tach_over(input logic [TACH_W-1:0] r,
                                     input logic [TACH_W-1:0] m);
    return r > m;
  endfunction

  assign evt_cond[BIT_V12] = window_viol(v12_rd, v12_lo, v12_hi);
  assign evt_cond[BIT_RSV] = 1'b0;

  for (genvar f = 0; f < N_FAN; f++) begin : g_fan
    assign evt_cond[BIT_FAN0+f] =
      tach_over(tach_rd[f*TACH_W +: TACH_W], tach_min[f*TACH_W +: TACH_W]);
  end

  for (genvar d = 0; d < N_DIODE; d++) begin : g_diode
    assign evt_cond[BIT_DIODE0+d] = diode_en[d] & diode_fault[d];
  end
endmodule

// File: rtl/hwmon_sticky_bit.sv
module hwmon_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cond,
  input  logic rd_clr,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (!en)         q_nxt = 1'b0;
    else if (cond)   q_nxt = 1'b1;
    else if (rd_clr) q_nxt = 1'b0;
    else             q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/hwmon_diode_override.sv
module hwmon_diode_override #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en,
  input  logic              fault,
  input  logic [TEMP_W-1:0] raw,
  input  logic [TEMP_W-1:0] lim,
  input  logic              zone_rd,
  output logic [TEMP_W-1:0] temp_eff,
  output logic              zone_cond,
  output logic              zone_q
);
  localparam logic [TEMP_W-1:0] FORCED_VAL = {1'b1, {(TEMP_W-1){1'b0}}};

  logic forced;

  function automatic logic [TEMP_W-1:0] pick_reading(input logic f,
                                                     input logic [TEMP_W-1:0] r);
    return f ? FORCED_VAL : r;
  endfunction

  assign forced    = start & en & fault;
  assign temp_eff  = pick_reading(forced, raw);
  assign zone_cond = en & (forced | (raw > lim));

  hwmon_sticky_bit u_zone (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .cond  (zone_cond),
    .rd_clr(zone_rd),
    .q     (zone_q)
  );
endmodule

// File: rtl/hwmon_evt_status.sv
module hwmon_evt_status
  import hwmon_stat_pkg::*;
#(
  parameter int VOLT_W = 8,
  parameter int TACH_W = 16,
  parameter int TEMP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [VOLT_W-1:0]         v12_rd,
  input  logic [VOLT_W-1:0]         v12_lo,
  input  logic [VOLT_W-1:0]         v12_hi,
  input  logic [N_FAN*TACH_W-1:0]   tach_rd,
  input  logic [N_FAN*TACH_W-1:0]   tach_min,
  input  logic [N_DIODE-1:0]        diode_en,
  input  logic [N_DIODE-1:0]        diode_fault,
  input  logic                      monitor_start,
  input  logic [N_DIODE*TEMP_W-1:0] temp_raw,
  input  logic [N_DIODE*TEMP_W-1:0] zone_lim,
  input  logic                      zone_rd_stb,
  input  logic                      peer_any,
  input  logic                      rd_stb,
  input  logic                      wr_stb,
  input  logic [STAT_W-1:0]         wr_data,
  output logic [STAT_W-1:0]         stat_value,
  output logic                      any_event,
  output logic [N_DIODE*TEMP_W-1:0] temp_out,
  output logic [N_DIODE-1:0]        zone_flag
);
  logic [STAT_W-1:0]  evt_cond;
  logic [STAT_W-1:0]  status_q;
  logic [N_DIODE-1:0] zone_cond;

  hwmon_evt_detect #(.VOLT_W(VOLT_W), .TACH_W(TACH_W)) u_detect (
    .v12_rd     (v12_rd),
    .v12_lo     (v12_lo),
    .v12_hi     (v12_hi),
    .tach_rd    (tach_rd),
    .tach_min   (tach_min),
    .diode_en   (diode_en),
    .diode_fault(diode_fault),
    .evt_cond   (evt_cond)
  );

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == BIT_RSV) begin : g_rsv
      assign status_q[b] = 1'b0;
    end else if (b >= BIT_DIODE0) begin : g_dio
      hwmon_sticky_bit u_bit (
        .clk(clk), .rst_n(rst_n), .en(diode_en[b-BIT_DIODE0]),
        .cond(evt_cond[b]), .rd_clr(rd_stb), .q(status_q[b])
      );
    end else begin : g_evt
      hwmon_sticky_bit u_bit (
        .clk(clk), .rst_n(rst_n), .en(1'b1),
        .cond(evt_cond[b]), .rd_clr(rd_stb), .q(status_q[b])
      );
    end
  end

  for (genvar d = 0; d < N_DIODE; d++) begin : g_ovr
    hwmon_diode_override #(.TEMP_W(TEMP_W)) u_ovr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (monitor_start),
      .en       (diode_en[d]),
      .fault    (diode_fault[d]),
      .raw      (temp_raw[d*TEMP_W +: TEMP_W]),
      .lim      (zone_lim[d*TEMP_W +: TEMP_W]),
      .zone_rd  (zone_rd_stb),
      .temp_eff (temp_out[d*TEMP_W +: TEMP_W]),
      .zone_cond(zone_cond[d]),
      .zone_q   (zone_flag[d])
    );
  end

  assign stat_value = status_q;
  assign any_event  = (|status_q) | peer_any;
endmodule

// File: rtl/hwmon_evt_status_chk.sv
module hwmon_evt_status_chk #(
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [7:0]        wr_data,
  input logic [7:0]        status_q,
  input logic [7:0]        evt_cond,
  input logic [1:0]        diode_en,
  input logic [1:0]        diode_fault,
  input logic              monitor_start,
  input logic [1:0]        zone_cond,
  input logic [1:0]        zone_flag,
  input logic              peer_any,
  input logic              any_event,
  input logic [2*TEMP_W-1:0] temp_out
);
  localparam logic [TEMP_W-1:0] FORCED_VAL = {1'b1, {(TEMP_W-1){1'b0}}};

  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[1] == 1'b0);

  // R2
  cond_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_cond) & ~status_q) == 8'h00));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((($past(status_q) & ~status_q) & {$past(diode_en), 6'h3F}) == 8'h00));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((status_q & ~$past(evt_cond)) == 8'h00));

  // R11
  write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_data != 8'h00) && !rd_stb)
      |=> ((status_q & ~$past(status_q) & ~$past(evt_cond)) == 8'h00));

  // R12
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_event == ((status_q != 8'h00) || peer_any));

  for (genvar d = 0; d < 2; d++) begin : g_d
    // R8
    disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !diode_en[d] |=> (!status_q[6+d] && !zone_flag[d]));
    // R9
    forced_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (monitor_start && diode_en[d] && diode_fault[d])
        |-> (temp_out[d*TEMP_W +: TEMP_W] == FORCED_VAL));
    // R10
    zone_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zone_cond[d] |=> zone_flag[d]);
  end
endmodule

bind hwmon_evt_status hwmon_evt_status_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_stb       (rd_stb),
  .wr_stb       (wr_stb),
  .wr_data      (wr_data),
  .status_q     (status_q),
  .evt_cond     (evt_cond),
  .diode_en     (diode_en),
  .diode_fault  (diode_fault),
  .monitor_start(monitor_start),
  .zone_cond    (zone_cond),
  .zone_flag    (zone_flag),
  .peer_any     (peer_any),
  .any_event    (any_event),
  .temp_out     (temp_out)
);

// File: tb/hwmon_evt_status_test.sv
module hwmon_evt_status_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  v12_rd, v12_lo, v12_hi;
  logic [63:0] tach_rd, tach_min;
  logic [1:0]  diode_en, diode_fault;
  logic        monitor_start;
  logic [15:0] temp_raw, zone_lim;
  logic        zone_rd_stb, peer_any, rd_stb, wr_stb;
  logic [7:0]  wr_data;
  logic [7:0]  stat_value;
  logic        any_event;
  logic [15:0] temp_out;
  logic [1:0]  zone_flag;

  int tach [4];
  int tmin [4];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb
    for (int i = 0; i < 4; i++) begin
      tach_rd[i*16 +: 16]  = tach[i][15:0];
      tach_min[i*16 +: 16] = tmin[i][15:0];
    end

  hwmon_evt_status uut (
    .clk(clk), .rst_n(rst_n), .v12_rd(v12_rd), .v12_lo(v12_lo), .v12_hi(v12_hi),
    .tach_rd(tach_rd), .tach_min(tach_min), .diode_en(diode_en),
    .diode_fault(diode_fault), .monitor_start(monitor_start), .temp_raw(temp_raw),
    .zone_lim(zone_lim), .zone_rd_stb(zone_rd_stb), .peer_any(peer_any),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .stat_value(stat_value),
    .any_event(any_event), .temp_out(temp_out), .zone_flag(zone_flag)
  );

  // Behavioural reference model
  bit [7:0] m_stat;
  bit [1:0] m_zone;

  function automatic bit event_now(int b);
    case (b)
      0: return (int'(v12_rd) <= int'(v12_lo)) || (int'(v12_rd) > int'(v12_hi));
      2, 3, 4, 5: return tach[b-2] > tmin[b-2];
      6, 7: return diode_en[b-6] && diode_fault[b-6];
      default: return 0;
    endcase
  endfunction

  function automatic int model_temp(int d);
    if (monitor_start && diode_en[d] && diode_fault[d]) return 128;
    return int'(temp_raw[d*8 +: 8]);
  endfunction

  function automatic bit zone_now(int d);
    return diode_en[d] && (model_temp(d) == 128 && diode_fault[d] && monitor_start
                           || int'(temp_raw[d*8 +: 8]) > int'(zone_lim[d*8 +: 8]));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 8'h00;
      m_zone = 2'b00;
    end else begin
      bit [7:0] nxt;
      bit [1:0] nz;
      for (int b = 0; b < 8; b++) begin
        if (b >= 6 && !diode_en[b-6]) nxt[b] = 0;
        else if (event_now(b))        nxt[b] = 1;
        else if (rd_stb)              nxt[b] = 0;
        else                          nxt[b] = m_stat[b];
      end
      for (int d = 0; d < 2; d++) begin
        if (!diode_en[d])      nz[d] = 0;
        else if (zone_now(d))  nz[d] = 1;
        else if (zone_rd_stb)  nz[d] = 0;
        else                   nz[d] = m_zone[d];
      end
      m_stat = nxt;
      m_zone = nz;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string bit_tag(int b);
    if (b == 0) return "R2";
    if (b == 1) return "R1";
    if (b < 6)  return "R3";
    return "R4";
  endfunction

  task automatic compare_all();
    for (int b = 0; b < 8; b++)
      chk(bit_tag(b), int'(stat_value[b]), int'(m_stat[b]));
    chk("R12", int'(any_event), int'((m_stat != 0) || peer_any));
    chk("R9", int'(temp_out[7:0]), model_temp(0));
    chk("R9", int'(temp_out[15:8]), model_temp(1));
    chk("R10", int'(zone_flag), int'(m_zone));
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
    compare_all();
  endtask

  task automatic quiet();
    v12_rd = 150; rd_stb = 0; wr_stb = 0; wr_data = 0; zone_rd_stb = 0;
    diode_fault = 0; diode_en = 2'b11; peer_any = 0; monitor_start = 1;
    temp_raw = {8'd40, 8'd40};
    for (int i = 0; i < 4; i++) tach[i] = 500;
  endtask

  task automatic clear_all();
    quiet();
    rd_stb = 1; zone_rd_stb = 1;
    tick();
    rd_stb = 0; zone_rd_stb = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    v12_lo = 100; v12_hi = 200; zone_lim = {8'd90, 8'd90};
    for (int i = 0; i < 4; i++) tmin[i] = 1000;
    quiet();
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R1 reset", int'(stat_value), 0);
    chk("R1 reset zone", int'(zone_flag), 0);
    rst_n = 1;
    tick();

    // R2: low boundary inclusive
    v12_rd = 100; tick();
    chk("R2 at low limit", int'(stat_value), 'h01);
    v12_rd = 150; tick();
    chk("R5 sticky", int'(stat_value), 'h01);
    rd_stb = 1; #1;
    chk("R6 read value pre-clear", int'(stat_value), 'h01);
    tick(); rd_stb = 0;
    chk("R6 cleared after read", int'(stat_value), 'h00);
    v12_rd = 200; tick();
    chk("R2 at high limit", int'(stat_value), 'h00);
    v12_rd = 201; tick();
    chk("R2 above high", int'(stat_value), 'h01);
    clear_all();

    // R3: fan boundary
    tach[2] = 1000; tick();
    chk("R3 equal min", int'(stat_value), 'h00);
    tach[2] = 1001; tick();
    chk("R3 above min", int'(stat_value), 'h10);
    rd_stb = 1; tick(); rd_stb = 0;
    chk("R6 active survives read", int'(stat_value), 'h10);
    clear_all();
    chk("R6 inactive read-cleared", int'(stat_value), 'h00);

    // R7: set wins over same-cycle read
    v12_rd = 90; rd_stb = 1; tick(); rd_stb = 0;
    chk("R7 set over clear", int'(stat_value), 'h01);
    clear_all();

    // R4 / R9 / R10: diode fault with start
    diode_fault = 2'b01; #1;
    chk("R9 forced 80h", int'(temp_out[7:0]), 'h80);
    tick();
    chk("R4 fault bit", int'(stat_value), 'h40);
    chk("R10 zone from forced", int'(zone_flag), 'b01);
    rd_stb = 1; tick(); tick(); rd_stb = 0;
    chk("R4 fault survives reads", int'(stat_value), 'h40);
    diode_fault = 0; rd_stb = 1; tick(); rd_stb = 0;
    chk("R6 fault gone cleared", int'(stat_value), 'h00);
    chk("R10 zone sticky", int'(zone_flag), 'b01);
    zone_rd_stb = 1; tick(); zone_rd_stb = 0;
    chk("R10 zone read-cleared", int'(zone_flag), 'b00);

    // R8: disable clears despite fault
    diode_fault = 2'b10; tick();
    chk("R8 setup", int'(stat_value), 'h80);
    diode_en = 2'b01; tick();
    chk("R8 fault bit cleared", int'(stat_value), 'h00);
    chk("R8 zone cleared", int'(zone_flag), 'b00);
    clear_all();

    // R9: no forcing without start
    monitor_start = 0; diode_fault = 2'b01; #1;
    chk("R9 raw without start", int'(temp_out[7:0]), 40);
    tick();
    chk("R10 no zone without force", int'(zone_flag), 'b00);
    clear_all();

    // R10: raw above zone limit
    temp_raw = {8'd91, 8'd40}; tick();
    chk("R10 raw over limit", int'(zone_flag), 'b10);
    clear_all();

    // R11: writes inert
    wr_stb = 1; wr_data = 8'hFF; tick(); wr_stb = 0;
    chk("R11 write no set", int'(stat_value), 'h00);
    v12_rd = 50; tick(); v12_rd = 150;
    wr_stb = 1; wr_data = 8'h00; tick(); wr_stb = 0;
    chk("R11 write no clear", int'(stat_value), 'h01);
    clear_all();

    // R12: summary from companion
    peer_any = 1; #1;
    chk("R12 peer only", int'(any_event), 1);
    peer_any = 0; #1;
    chk("R12 all clear", int'(any_event), 0);

    // Randomized traffic against the model
    for (int n = 0; n < 600; n++) begin
      v12_rd = 8'($urandom_range(95, 205));
      for (int i = 0; i < 4; i++) tach[i] = $urandom_range(998, 1002);
      diode_fault   = 2'($urandom);
      diode_en      = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b11;
      monitor_start = ($urandom_range(0, 3) != 0);
      temp_raw      = {8'($urandom_range(85, 95)), 8'($urandom_range(85, 95))};
      rd_stb        = ($urandom_range(0, 2) == 0);
      zone_rd_stb   = ($urandom_range(0, 2) == 0);
      wr_stb        = ($urandom_range(0, 3) == 0);
      wr_data       = 8'($urandom);
      peer_any      = ($urandom_range(0, 5) == 0);
      tick();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule